// File: doc/BRIEF.md
# Run-Time Configurable Serial CRC Engine

This block computes a cyclic redundancy check over a serial bit stream. It takes one bit per accepted transfer. The register length, the feedback taps and the starting value are all chosen at run time. The length can be any value from 0 to 8 bits, and a length of 0 turns the check off. The polynomial and the seed each arrive as two 4-bit nibbles, an upper one and a lower one.

A single-cycle `start` pulse does three things:

- It captures the configuration pins into internal copies.
- It loads the seed, cut down to the new length, into the shift register.
- It opens a new frame.

While a frame is running, the configuration pins are not looked at again. The host can therefore set up the next frame's values early without disturbing the current calculation.

Data bits arrive on a valid/ready handshake. A bit is consumed on a rising clock edge when `bit_valid` and `bit_ready` are both high. `bit_ready` is low only in a cycle where `start` is high, because starting a frame takes priority over data. A bit offered in that cycle is not consumed and must be held until `bit_ready` returns high. `bit_ready` never depends on `bit_valid`. After reset the block behaves as if it had been started with its default setting: a 4-bit CRC, polynomial x^4+1 (feedback taps `0001`) and seed `1010`.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, the active setting is length 4, feedback taps 0x01 and seed 0xA, so `crc_out` reads 0xA until the first `start`.
- R2: A cycle with `start` high captures the length from `cfg_len`, the feedback taps from `{cfg_poly_hi, cfg_poly_lo}` and the seed from `{cfg_seed_hi, cfg_seed_lo}` (upper nibble in bits 7:4). From the next cycle, `crc_out` equals that seed with every bit at or above the length cleared.
- R3: For each consumed bit d, with length N > 0: let f = d XOR (register bit N-1). The register shifts left by one. When f is 1, it is also XORed with the taps. Only bits N-1:0 are kept.
- R4: Bits of `crc_out` at positions equal to or above the active length are always 0.
- R5: With an active length of 0, `crc_out` is 0 and consumed bits leave the register unchanged.
- R6: Changes on the configuration pins without `start` have no effect on `crc_out` or on later bit updates.
- R7: A `start` with `cfg_len` greater than 8 keeps the previously active length. The taps and seed are still captured, and the seed is cut down to the kept length.
- R8: `bit_ready` is low exactly in cycles with `start` high. A bit offered in such a cycle is not consumed.
- R9: In a cycle with neither `start` nor a consumed bit, `crc_out` holds its value.
- R10: A length of 8 uses all eight tap bits and all eight seed bits, and a length of 1 uses only tap bit 0 and seed bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 4 | Requested CRC length, 0 to 8; larger values are ignored at start |
| cfg_poly_hi | input | 4 | Feedback taps, bits 7:4 |
| cfg_poly_lo | input | 4 | Feedback taps, bits 3:0 |
| cfg_seed_hi | input | 4 | Seed, bits 7:4 |
| cfg_seed_lo | input | 4 | Seed, bits 3:0 |
| start | input | 1 | One-cycle frame start; captures configuration and loads the seed |
| bit_valid | input | 1 | A data bit is offered |
| bit_ready | output | 1 | The engine will consume an offered bit this cycle |
| bit_data | input | 1 | Serial data bit |
| crc_out | output | 8 | Current CRC, limited to the active length |

## Verification
The bench builds the engine with its default nibble width of 4. This gives a register of up to 8 bits and a 4-bit length field. With that field, every legal length from 0 to 8 can be reached, and so can the out-of-range codes 9 to 15 that must leave the length unchanged. At this width, the full-length case exercises every tap and seed bit. The smallest nonzero length isolates the single-bit feedback path.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int unsigned DEF_NIB_W = 4;

  // Ones in the lowest n positions of a 32-bit word.
  function automatic logic [31:0] low_ones(input logic [31:0] n);
    logic [31:0] r;
    if (n >= 32'd32) r = '1;
    else             r = (32'd1 << n) - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/crc_cfg_latch.sv
module crc_cfg_latch
  import crc_eng_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned LEN_W  = 4,
  parameter logic [LEN_W-1:0] RST_LEN  = 4,
  parameter logic [W-1:0]     RST_POLY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic [W-1:0]     poly_in,
  input  logic [W-1:0]     seed_in,
  output logic [LEN_W-1:0] len_q,
  output logic [W-1:0]     poly_q,
  output logic [W-1:0]     seed_load
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(W);

  logic [LEN_W-1:0] len_eff;
  logic [W-1:0]     load_mask;

  // Out-of-range requests keep the current length.
  assign len_eff   = (len_in > MAX_LEN) ? len_q : len_in;
  assign load_mask = W'(low_ones(32'(len_eff)));
  assign seed_load = seed_in & load_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= RST_LEN;
      poly_q <= RST_POLY;
    end else if (start) begin
      len_q  <= len_eff;
      poly_q <= poly_in;
    end
  end

  // R7: illegal length request leaves the active length alone
  a_r7_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_in > MAX_LEN) |=> len_q == $past(len_q));

  // R6: no start, no change of the captured setting
  a_r6_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(len_q) && $stable(poly_q)));

  // R4: active length never exceeds the register width
  a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= MAX_LEN);

endmodule

// File: rtl/crc_shift_core.sv
module crc_shift_core
  import crc_eng_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned LEN_W = 4,
  parameter logic [W-1:0] RST_VAL = 'hA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             shift_en,
  input  logic             din,
  input  logic [LEN_W-1:0] len,
  input  logic [W-1:0]     poly,
  output logic [W-1:0]     crc_q
);

  logic [W-1:0] msb_sel;
  logic [W-1:0] nxt;
  logic         top_bit;
  logic         fb;
  logic         active;
  logic [W-1:0] len_mask;

  assign len_mask = W'(low_ones(32'(len)));
  assign active   = (len != '0);

  // Pick register bit len-1 without a variable index.
  for (genvar i = 0; i < W; i++) begin : g_msb
    assign msb_sel[i] = (32'(len) == i + 1) & crc_q[i];
  end
  assign top_bit = |msb_sel;
  assign fb      = din ^ top_bit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[i] = len_mask[i] & (fb & poly[i]);
    end else begin : g_mid
      assign nxt[i] = len_mask[i] & (crc_q[i-1] ^ (fb & poly[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 crc_q <= RST_VAL;
    else if (load)              crc_q <= load_val;
    else if (shift_en && active) crc_q <= nxt;
  end

  // R5: zero length means consumed bits do nothing
  a_r5_zero_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && len == '0) |=> $stable(crc_q));

  // R9: nothing to do, nothing changes
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(crc_q));

  // R4: bits above the active length stay clear
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_q & ~len_mask) == '0);

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned NIB_W = DEF_NIB_W,
  parameter logic [2*NIB_W-1:0] RST_POLY = 'h01,
  parameter logic [2*NIB_W-1:0] RST_SEED = 'hA
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(2*NIB_W+1)-1:0]     cfg_len,
  input  logic [NIB_W-1:0]                 cfg_poly_hi,
  input  logic [NIB_W-1:0]                 cfg_poly_lo,
  input  logic [NIB_W-1:0]                 cfg_seed_hi,
  input  logic [NIB_W-1:0]                 cfg_seed_lo,
  input  logic                             start,
  input  logic                             bit_valid,
  output logic                             bit_ready,
  input  logic                             bit_data,
  output logic [2*NIB_W-1:0]               crc_out
);

  localparam int unsigned W     = 2 * NIB_W;
  localparam int unsigned LEN_W = $clog2(W + 1);
  localparam logic [LEN_W-1:0] RST_LEN = LEN_W'(NIB_W);

  logic [LEN_W-1:0] len_q;
  logic [W-1:0]     poly_q;
  logic [W-1:0]     seed_load;
  logic [W-1:0]     crc_q;
  logic             take_bit;
  logic [W-1:0]     out_mask;

  assign bit_ready = !start;
  assign take_bit  = bit_valid && bit_ready;

  crc_cfg_latch #(
    .W(W), .LEN_W(LEN_W), .RST_LEN(RST_LEN), .RST_POLY(RST_POLY)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len_in    (cfg_len),
    .poly_in   ({cfg_poly_hi, cfg_poly_lo}),
    .seed_in   ({cfg_seed_hi, cfg_seed_lo}),
    .len_q     (len_q),
    .poly_q    (poly_q),
    .seed_load (seed_load)
  );

  crc_shift_core #(
    .W(W), .LEN_W(LEN_W), .RST_VAL(RST_SEED & W'(low_ones(32'(NIB_W))))
  ) i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (seed_load),
    .shift_en (take_bit),
    .din      (bit_data),
    .len      (len_q),
    .poly     (poly_q),
    .crc_q    (crc_q)
  );

  assign out_mask = W'(low_ones(32'(len_q)));
  assign crc_out  = crc_q & out_mask;

  // Checker-side expectation for a legal start.
  logic [W-1:0] seed_chk;
  assign seed_chk = {cfg_seed_hi, cfg_seed_lo} & W'(low_ones(32'(cfg_len)));

  // R8: start blocks the data handshake
  a_r8_ready_low_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !bit_ready);

  // R2: legal start shows the truncated seed next cycle
  a_r2_seed_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (start && 32'(cfg_len) <= W) |=> crc_out == $past(seed_chk));

  // R5: zero length drives a zero result
  a_r5_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == '0) |-> crc_out == '0);

endmodule

// File: tb/test_crc_serial_engine.sv
module test_crc_serial_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_len = 4'd0;
  logic [3:0] cfg_poly_hi = 4'd0, cfg_poly_lo = 4'd0;
  logic [3:0] cfg_seed_hi = 4'd0, cfg_seed_lo = 4'd0;
  logic       start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [7:0] crc_out;

  int    n_run = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_len, m_poly, m_crc;

  always #2.5 clk = ~clk;

  crc_serial_engine i_crc_serial_engine (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len),
    .cfg_poly_hi(cfg_poly_hi), .cfg_poly_lo(cfg_poly_lo),
    .cfg_seed_hi(cfg_seed_hi), .cfg_seed_lo(cfg_seed_lo),
    .start(start), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .crc_out(crc_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len <= 4; m_poly <= 1; m_crc <= 'hA;
    end else if (start) begin
      int nl;
      nl = (cfg_len > 8) ? m_len : int'(cfg_len);
      m_len  <= nl;
      m_poly <= int'({cfg_poly_hi, cfg_poly_lo});
      m_crc  <= int'({cfg_seed_hi, cfg_seed_lo}) & ((1 << nl) - 1);
    end else if (bit_valid && m_len != 0) begin
      int f, v;
      f = int'(bit_data) ^ ((m_crc >> (m_len - 1)) & 1);
      v = m_crc << 1;
      if (f != 0) v = v ^ m_poly;
      m_crc <= v & ((1 << m_len) - 1);
    end
  end

  // compare every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(crc_out), m_crc & ((1 << m_len) - 1));
      if (m_len < 8) check("R4", int'(crc_out) >> m_len, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic do_start(input int len, input int poly, input int seed, input bit with_bit);
    @(negedge clk);
    cfg_len = 4'(len);
    {cfg_poly_hi, cfg_poly_lo} = 8'(poly);
    {cfg_seed_hi, cfg_seed_lo} = 8'(seed);
    start = 1'b1;
    bit_valid = with_bit;
    bit_data = 1'b1;
    #1 check("R8", int'(bit_ready), 0);
    @(negedge clk);
    start = 1'b0;
    bit_valid = 1'b0;
    #1 check("R8", int'(bit_ready), 1);
  endtask

  task automatic send_bits(input int n, input bit gaps);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_data  = 1'($urandom);
      bit_valid = gaps ? 1'($urandom) : 1'b1;
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", int'(crc_out), 'hA);
    check("R1", int'(bit_ready), 1);
    cur_req = "R1"; send_bits(12, 0);

    cur_req = "R2"; do_start(5, 'h15, 'hFF, 0);
    check("R2", int'(crc_out), 'h1F);
    cur_req = "R3"; send_bits(20, 0);

    cur_req = "R10"; do_start(8, 'h07, 'hFF, 0); send_bits(32, 0);
    do_start(1, 'hFF, 'hFE, 0);
    check("R10", int'(crc_out), 0);
    send_bits(10, 0);

    cur_req = "R6"; do_start(6, 'h21, 'h2A, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      cfg_len = 4'($urandom_range(0, 15));
      {cfg_poly_hi, cfg_poly_lo} = 8'($urandom);
      {cfg_seed_hi, cfg_seed_lo} = 8'($urandom);
      bit_valid = 1'b1; bit_data = 1'($urandom);
    end
    @(negedge clk); bit_valid = 1'b0;

    cur_req = "R5"; do_start(0, 'hFF, 'hFF, 0);
    check("R5", int'(crc_out), 0);
    send_bits(8, 0);

    cur_req = "R7"; do_start(3, 'h03, 'h05, 0);
    do_start(12, 'h06, 'hFF, 0);
    check("R7", int'(crc_out), 'h7);
    send_bits(10, 0);

    cur_req = "R9"; do_start(7, 'h09, 'h33, 0); send_bits(40, 1);

    cur_req = "R8"; do_start(4, 'h03, 'h09, 1);
    check("R8", int'(crc_out), 'h9);
    send_bits(6, 0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule